// File: doc/BRIEF.md
# Distributed-Pulse 14-Bit PWM Generator

This block turns a 14-bit duty ratio into a pulse train on one output pin, clocked directly from the input clock. Instead of one long pulse per 16384-clock period, the frame is cut into 128 equal time slots of 128 clocks each. Every slot carries a base pulse whose width, in clocks, is the upper seven ratio bits. The lower seven ratio bits give the number of slots that get one extra clock of high time. These extensions are scattered evenly over the frame, so the averaged output carries the full 14-bit resolution while its ripple sits at the slot rate, 128 times higher than a plain PWM of the same resolution.

A 14-bit down counter runs continuously from all ones to zero. Its top bits count the slot and its bottom bits count the position within the slot. Software-side writes land in two shadow registers, one per ratio half, each with its own write strobe. The active ratio picks up the shadows only when the counter wraps, so every frame runs on one consistent ratio. A small slot state machine registers the output. It has three states: `ST_LOW` (output low), `ST_BASE` (inside the base width) and `ST_EXT` (the one-clock extension). Its transitions are:
- slot start: any state to `ST_BASE` when the base width is nonzero;
- base done: `ST_BASE` to `ST_LOW`;
- extend: `ST_BASE` or `ST_LOW` to `ST_EXT` at the position equal to the base width, in a selected slot;
- extension done: `ST_EXT` to `ST_LOW`, or to `ST_BASE` when the next slot starts at once.

Top module: `pwm_dist14`

## Requirements
- R1: A synchronous active-high reset clears both the shadow and the active ratio to zero and sets the down counter to all ones. It drives the output low.
- R2: The counter counts down by one each clock and wraps from zero to all ones. A frame is therefore 2^(SLOT_BITS+POS_BITS) clocks long. The elapsed slot index is the inverted top SLOT_BITS counter bits, and the elapsed position is the inverted bottom POS_BITS bits.
- R3: In every slot the output is high at each elapsed position below the active high field, the base width.
- R4: A slot whose bit-reversed elapsed index is below the active low field is also high at the position equal to the base width. Every other position in every slot is low.
- R5: The number of high clocks in a frame equals high_field * 2^SLOT_BITS + low_field.
- R6: With both fields at their maximum, every slot that gets an extension is high for the whole slot. The other slot is high for all but its last clock.
- R7: An active ratio of zero keeps the output constantly low.
- R8: A write to a shadow register changes the active ratio only at the next counter wrap. A write captured on the wrap edge itself takes effect one frame later.
- R9: The two write strobes are independent. Writing one half leaves the other shadow half unchanged, and when both are written in the same frame the last value written wins.
- R10: The output is registered. It shows the decision for a counter position one clock after the counter holds that position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, also the minimum pulse unit |
| rst_i | input | 1 | Synchronous active-high reset |
| hi_wr_i | input | 1 | Write strobe for the high ratio shadow |
| hi_data_i | input | POS_BITS | High ratio field: base width per slot |
| lo_wr_i | input | 1 | Write strobe for the low ratio shadow |
| lo_data_i | input | SLOT_BITS | Low ratio field: number of extended slots |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The bench builds the block with SLOT_BITS=3 and POS_BITS=4. This gives eight slots of sixteen clocks and a 128-clock frame. At that size about ten frames fit in a short run. The maximum fields, the zero ratio, extension-only and base-only ratios, and writes placed on the wrap edge can each be run for a full frame. Every clock is compared against a scoreboard model, and the high count of every frame is checked against the ratio that frame ran on.

// File: rtl/pwm_dist_pkg.sv
package pwm_dist_pkg;

    // Per-slot output phase of the slot sequencer
    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_BASE = 2'd1,
        ST_EXT  = 2'd2
    } slot_state_e;

endpackage

// File: rtl/pwm_dist_frame_cnt.sv
module pwm_dist_frame_cnt #(
    parameter int CNT_BITS = 14
) (
    input  logic                clk_i,
    input  logic                rst_i,
    output logic [CNT_BITS-1:0] cnt_o,
    output logic                wrap_o
);

    localparam logic [CNT_BITS-1:0] CNT_TOP = {CNT_BITS{1'b1}};

    logic [CNT_BITS-1:0] cnt_q;

    // Free-running down counter; zero is the last clock of a frame
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= CNT_TOP;
        end else if (cnt_q == '0) begin
            cnt_q <= CNT_TOP;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == '0);

endmodule

// File: rtl/pwm_dist_ratio_regs.sv
module pwm_dist_ratio_regs #(
    parameter int SLOT_BITS = 7,
    parameter int POS_BITS  = 7
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 hi_wr_i,
    input  logic [POS_BITS-1:0]  hi_data_i,
    input  logic                 lo_wr_i,
    input  logic [SLOT_BITS-1:0] lo_data_i,
    input  logic                 load_i,
    output logic [POS_BITS-1:0]  sh_hi_o,
    output logic [SLOT_BITS-1:0] sh_lo_o,
    output logic [POS_BITS-1:0]  act_hi_o,
    output logic [SLOT_BITS-1:0] act_lo_o
);

    logic [POS_BITS-1:0]  sh_hi_q,  act_hi_q;
    logic [SLOT_BITS-1:0] sh_lo_q,  act_lo_q;

    // Shadow halves, each with its own strobe
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_hi_q <= '0;
            sh_lo_q <= '0;
        end else begin
            if (hi_wr_i) sh_hi_q <= hi_data_i;
            if (lo_wr_i) sh_lo_q <= lo_data_i;
        end
    end

    // Active ratio: copied only on the frame-wrap clock
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_hi_q <= '0;
            act_lo_q <= '0;
        end else if (load_i) begin
            act_hi_q <= sh_hi_q;
            act_lo_q <= sh_lo_q;
        end
    end

    assign sh_hi_o  = sh_hi_q;
    assign sh_lo_o  = sh_lo_q;
    assign act_hi_o = act_hi_q;
    assign act_lo_o = act_lo_q;

endmodule

// File: rtl/pwm_dist_slot_fsm.sv
module pwm_dist_slot_fsm
    import pwm_dist_pkg::*;
#(
    parameter int SLOT_BITS = 7,
    parameter int POS_BITS  = 7
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [SLOT_BITS+POS_BITS-1:0] cnt_i,
    input  logic [POS_BITS-1:0]           act_hi_i,
    input  logic [SLOT_BITS-1:0]          act_lo_i,
    output logic                          pwm_o
);

    localparam int CNT_BITS = SLOT_BITS + POS_BITS;

    logic [SLOT_BITS-1:0] slot_up;
    logic [SLOT_BITS-1:0] slot_rev;
    logic [POS_BITS-1:0]  pos_up;
    logic                 in_base;
    logic                 at_ext;
    logic                 ext_sel;
    slot_state_e          state_q, state_d;

    // Elapsed slot and position: the counter runs downward
    assign slot_up = ~cnt_i[CNT_BITS-1:POS_BITS];
    assign pos_up  = ~cnt_i[POS_BITS-1:0];

    // Bit reversal spreads the selected slots evenly over the frame
    for (genvar gi = 0; gi < SLOT_BITS; gi++) begin : g_rev
        assign slot_rev[gi] = slot_up[SLOT_BITS-1-gi];
    end

    assign ext_sel = (slot_rev < act_lo_i);
    assign in_base = (pos_up < act_hi_i);
    assign at_ext  = (pos_up == act_hi_i) && ext_sel;

    // Next-state logic
    always_comb begin
        state_d = ST_LOW;
        unique case (state_q)
            ST_LOW: begin
                if (in_base)     state_d = ST_BASE;   // slot start
                else if (at_ext) state_d = ST_EXT;    // extend, no base
                else             state_d = ST_LOW;
            end
            ST_BASE: begin
                if (in_base)     state_d = ST_BASE;
                else if (at_ext) state_d = ST_EXT;    // extend
                else             state_d = ST_LOW;    // base done
            end
            ST_EXT: begin
                if (in_base)     state_d = ST_BASE;   // next slot starts
                else             state_d = ST_LOW;    // extension done
            end
            default:             state_d = ST_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_LOW;
        else       state_q <= state_d;
    end

    // Output decode
    always_comb begin
        pwm_o = (state_q == ST_BASE) || (state_q == ST_EXT);
    end

endmodule

// File: rtl/pwm_dist14.sv
module pwm_dist14 #(
    parameter int SLOT_BITS = 7,
    parameter int POS_BITS  = 7
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 hi_wr_i,
    input  logic [POS_BITS-1:0]  hi_data_i,
    input  logic                 lo_wr_i,
    input  logic [SLOT_BITS-1:0] lo_data_i,
    output logic                 pwm_o
);

    localparam int CNT_BITS = SLOT_BITS + POS_BITS;

    logic [CNT_BITS-1:0]  cnt_w;
    logic                 wrap_w;
    logic [POS_BITS-1:0]  sh_hi_w,  act_hi_w;
    logic [SLOT_BITS-1:0] sh_lo_w,  act_lo_w;

    pwm_dist_frame_cnt #(
        .CNT_BITS (CNT_BITS)
    ) u_cnt (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cnt_o  (cnt_w),
        .wrap_o (wrap_w)
    );

    pwm_dist_ratio_regs #(
        .SLOT_BITS (SLOT_BITS),
        .POS_BITS  (POS_BITS)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .hi_wr_i   (hi_wr_i),
        .hi_data_i (hi_data_i),
        .lo_wr_i   (lo_wr_i),
        .lo_data_i (lo_data_i),
        .load_i    (wrap_w),
        .sh_hi_o   (sh_hi_w),
        .sh_lo_o   (sh_lo_w),
        .act_hi_o  (act_hi_w),
        .act_lo_o  (act_lo_w)
    );

    pwm_dist_slot_fsm #(
        .SLOT_BITS (SLOT_BITS),
        .POS_BITS  (POS_BITS)
    ) u_fsm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cnt_i    (cnt_w),
        .act_hi_i (act_hi_w),
        .act_lo_i (act_lo_w),
        .pwm_o    (pwm_o)
    );

endmodule

// File: rtl/pwm_dist14_chk.sv
module pwm_dist14_chk #(
    parameter int SLOT_BITS = 7,
    parameter int POS_BITS  = 7
) (
    input logic                          clk_i,
    input logic                          rst_i,
    input logic [SLOT_BITS+POS_BITS-1:0] cnt,
    input logic [POS_BITS-1:0]           sh_hi,
    input logic [SLOT_BITS-1:0]          sh_lo,
    input logic [POS_BITS-1:0]           act_hi,
    input logic [SLOT_BITS-1:0]          act_lo,
    input logic                          pwm_o
);

    localparam int CNT_BITS = SLOT_BITS + POS_BITS;

    logic [POS_BITS-1:0]  pos_up;
    logic [SLOT_BITS-1:0] rev_up;
    logic                 rst_d = 1'b0;

    assign pos_up = ~cnt[POS_BITS-1:0];

    always_comb begin
        for (int i = 0; i < SLOT_BITS; i++) begin
            rev_up[i] = ~cnt[CNT_BITS-1-i];
        end
    end

    always_ff @(posedge clk_i) rst_d <= rst_i;

    // R1: state right after a reset edge
    always @(posedge clk_i) begin
        if (rst_d) begin
            assert_reset_state_R1: assert (cnt == {CNT_BITS{1'b1}} && act_hi == '0
                && act_lo == '0 && sh_hi == '0 && sh_lo == '0 && !pwm_o)
                else $error("reset state wrong");
        end
    end

    // R2: down count and wrap
    assert_count_down_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt == '0) |=> (cnt == {CNT_BITS{1'b1}}));

    // R8: shadow transfer only at wrap
    assert_load_at_wrap_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt == '0) |=> (act_hi == $past(sh_hi) && act_lo == $past(sh_lo)));

    assert_hold_mid_frame_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt != '0) |=> ($stable(act_hi) && $stable(act_lo)));

    // R3 / R10: base width, one clock later
    assert_base_high_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (pos_up < act_hi) |=> pwm_o);

    // R4: extension position and the low tail of a slot
    assert_ext_slot_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (pos_up == act_hi) |=> (pwm_o == $past(rev_up < act_lo)));

    assert_tail_low_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (pos_up > act_hi) |=> !pwm_o);

    // R7: zero ratio keeps the output low
    assert_zero_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_hi == '0 && act_lo == '0) |=> !pwm_o);

endmodule

bind pwm_dist14 pwm_dist14_chk #(
    .SLOT_BITS (SLOT_BITS),
    .POS_BITS  (POS_BITS)
) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cnt    (cnt_w),
    .sh_hi  (sh_hi_w),
    .sh_lo  (sh_lo_w),
    .act_hi (act_hi_w),
    .act_lo (act_lo_w),
    .pwm_o  (pwm_o)
);

// File: tb/pwm_dist14_tb_top.sv
`timescale 1ns/1ps
module pwm_dist14_tb_top;

    localparam int S     = 3;
    localparam int P     = 4;
    localparam int SLOTS = 1 << S;
    localparam int POSN  = 1 << P;
    localparam int FRAME = 1 << (S + P);

    typedef struct {
        logic  v;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_i;
    logic         hi_wr_i;
    logic [P-1:0] hi_data_i;
    logic         lo_wr_i;
    logic [S-1:0] lo_data_i;
    logic         pwm_o;

    int    checks   = 0;
    int    failures = 0;
    int    ncyc     = 0;
    int    mcnt     = 0;
    int    hcnt     = 0;
    bit    running  = 1'b0;
    bit    finished = 1'b0;
    string phase    = "R1";

    // model state
    int m_sh_hi = 0, m_sh_lo = 0, m_act_hi = 0, m_act_lo = 0;
    exp_t q[$];
    int   fq[$];

    always #2.5 clk = ~clk;

    pwm_dist14 #(.SLOT_BITS(S), .POS_BITS(P)) dut_i (
        .clk_i     (clk),
        .rst_i     (rst_i),
        .hi_wr_i   (hi_wr_i),
        .hi_data_i (hi_data_i),
        .lo_wr_i   (lo_wr_i),
        .lo_data_i (lo_data_i),
        .pwm_o     (pwm_o)
    );

    function automatic int bitrev(int k);
        int r = 0;
        for (int i = 0; i < S; i++) if (k[i]) r |= 1 << (S - 1 - i);
        return r;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Driver-side model: after each edge push the value expected for it (R10)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (running) begin
                exp_t it;
                int e, k, p, ext;
                ncyc++;
                e   = ncyc - 1;
                k   = (e / POSN) % SLOTS;
                p   = e % POSN;
                ext = (bitrev(k) < m_act_lo) ? 1 : 0;
                it.v = (p < m_act_hi + ext);
                if (m_act_hi == 0 && m_act_lo == 0) it.tag = "R7";
                else if (p == m_act_hi)             it.tag = "R4";
                else                                it.tag = "R3";
                q.push_back(it);
                if (ncyc % FRAME == 0) begin          // R2 frame wrap, R8 load
                    m_act_hi = m_sh_hi;
                    m_act_lo = m_sh_lo;
                    fq.push_back(m_act_hi * SLOTS + m_act_lo);
                end
                if (hi_wr_i) m_sh_hi = int'(hi_data_i);   // R9 independent halves
                if (lo_wr_i) m_sh_lo = int'(lo_data_i);
            end
        end
    end

    // Monitor: compare each clock, and the high count of each frame (R5)
    initial begin
        forever begin
            @(negedge clk);
            if (running && q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                mcnt++;
                checks++;
                if (pwm_o !== it.v) begin
                    failures++;
                    $display("FAIL %s (phase %s) cycle=%0d actual=%0b expected=%0b",
                             it.tag, phase, mcnt, pwm_o, it.v);
                end
                if (pwm_o === 1'b1) hcnt++;
                if (mcnt % FRAME == 0 && fq.size() > 0) begin
                    int ef;
                    ef = fq.pop_front();
                    checks++;
                    if (hcnt != ef) begin
                        failures++;
                        $display("FAIL R5 (phase %s) frame_end=%0d actual=%0d expected=%0d",
                                 phase, mcnt, hcnt, ef);
                    end
                    hcnt = 0;
                end
            end
        end
    end

    task automatic goto_cycle(int t);
        while (ncyc < t) @(negedge clk);
    endtask

    task automatic write_ratio(bit wh, int h, bit wl, int l);
        hi_wr_i   = wh;
        hi_data_i = P'(h);
        lo_wr_i   = wl;
        lo_data_i = S'(l);
        @(negedge clk);
        hi_wr_i = 1'b0;
        lo_wr_i = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog (phase %s) actual=hung expected=done", phase);
            summary();
            $finish;
        end
    end

    initial begin
        rst_i     = 1'b1;
        hi_wr_i   = 1'b0;
        lo_wr_i   = 1'b0;
        hi_data_i = '0;
        lo_data_i = '0;
        repeat (4) @(negedge clk);
        // R1: output low while held in reset
        checks++;
        if (pwm_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset output actual=%0b expected=0", pwm_o);
        end
        rst_i = 1'b0;
        fq.push_back(0);               // frame 0 runs on the reset ratio (R1, R7)
        running = 1'b1;

        phase = "R3 R4";
        goto_cycle(40);            write_ratio(1, 5, 1, 3);
        phase = "R9";
        goto_cycle(FRAME + 50);    write_ratio(1, 9, 0, 0);
        phase = "R6";
        goto_cycle(2*FRAME + 30);  write_ratio(1, 15, 1, 7);
        phase = "R4 ext only";
        goto_cycle(3*FRAME + 30);  write_ratio(1, 0, 1, 5);
        phase = "R7";
        goto_cycle(4*FRAME + 30);  write_ratio(1, 0, 1, 0);
        phase = "R3 base only";
        goto_cycle(5*FRAME + 30);  write_ratio(1, 1, 1, 0);
        phase = "R8 wrap edge";
        goto_cycle(6*FRAME - 1);   write_ratio(1, 6, 1, 2);
        phase = "R9 last wins";
        goto_cycle(7*FRAME + 20);  write_ratio(1, 3, 1, 1);
        write_ratio(1, 11, 1, 6);
        goto_cycle(9*FRAME + 5);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule